// File: doc/BRIEF.md
# Event and Counting Semaphore Unit

A memory-mapped synchronization block that holds 256 edge events and 256 counting semaphores, each 32 bits wide. Software reaches it over a simple single-cycle register bus. The address space is split into windows, one per operation, so one 32-bit write is enough to set, add to or subtract from a chosen semaphore. A write to the event window fires a one-cycle strobe on the addressed event line.

An engine-side port lets one requester wait until a chosen semaphore is at least a given value. The requester can also ask for that value to be subtracted atomically once the wait is satisfied, and for a notification request to be raised. The notification request carries the semaphore index, the update mode and the value left in the semaphore. The block arbitrates between the bus and the engine port. When both update the same semaphore in one cycle, both updates are merged into a single write.

Top module: `sem_evt_unit`

## Requirements
- R1: After reset every semaphore reads 0, every underflow flag is 0, `evt_o` is all zero and `eng_done_o` and `ntf_valid_o` are low.
- R2: A bus read returns its data in `bus_rdata_o` with `bus_rvalid_o` high in the cycle after the request. A read of the snapshot window (byte offset 0x1000 + 4k) returns the count of semaphore k as it stood before any update in the request cycle. A write to the set window (0x1400 + 4k) stores the write data in semaphore k and clears its underflow flag.
- R3: A write to the increment window (0x1800 + 4k) adds the write data to semaphore k, so writing 1 is one counted increment. The sum saturates at 0xFFFFFFFF.
- R4: A write to the decrement window (0x1C00 + 4k) subtracts the write data from semaphore k. A result below zero saturates at 0 and sets the sticky underflow flag of k. A read of the set window returns that flag in bit 0, with the other bits 0. Only a set write clears the flag.
- R5: A write to the event window (0x0000 + 4k) drives `evt_o[k]` high for exactly the next cycle. No other event bit goes high. Any read of the event window returns 0.
- R6: The window is selected by address bits [12:10] and the index by bits [9:2]. A write whose bits [1:0] are not zero, or whose bits [12:10] are 001, 010 or 011, has no effect.
- R7: With `eng_req_i` high and `eng_dec_i` low, `eng_done_o` pulses one cycle after the first cycle in which the addressed count is at least `eng_val_i`. The count is left unchanged.
- R8: With `eng_dec_i` high, the wait blocks while the count is below `eng_val_i`. In the cycle the count is at least `eng_val_i`, the value is subtracted in the same update, and `eng_done_o` pulses in the next cycle.
- R9: When the satisfied wait had `eng_notify_i` high, `ntf_valid_o` is high together with `eng_done_o`. In that cycle `ntf_sem_o` is the index, `ntf_mode_o` is 1 for a decrementing wait and 0 for a plain wait, and `ntf_value_o` is the semaphore value after the update.
- R10: A bus increment or decrement and an engine decrement that hit the same semaphore in the same cycle both take effect. The result is old + inc − bus_dec − eng_val, saturated, written once. An underflow here sets the flag.
- R11: In the cycle that `eng_done_o` is high, the engine request is not evaluated. A request held one cycle too long therefore never fires twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 13 | Byte address inside the unit |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| evt_o | output | 256 | One-cycle event strobes |
| eng_req_i | input | 1 | Engine wait request, held until done |
| eng_sem_i | input | 8 | Semaphore index to wait on |
| eng_val_i | input | 32 | Threshold, and amount subtracted in decrement mode |
| eng_dec_i | input | 1 | 1 = wait then subtract, 0 = plain wait |
| eng_notify_i | input | 1 | Raise a notification request on completion |
| eng_done_o | output | 1 | Wait satisfied pulse |
| ntf_valid_o | output | 1 | Notification request |
| ntf_sem_o | output | 8 | Semaphore index of the notification |
| ntf_mode_o | output | 1 | Update mode: 1 decrement, 0 none |
| ntf_value_o | output | 32 | Semaphore value after the update |

## Verification
The bench goes after the merge of a bus write and an engine decrement on the same semaphore. A design that let one update overwrite the other would leave either old+inc or old−val instead of the combined value. It drives a decrement past zero and expects a clamp at 0 plus a flag that survives later writes; a design using plain unsigned subtraction would wrap to a huge count and leave the flag clear. Increments near the top must clamp rather than wrap to a small value. It holds an engine request one cycle past completion: a design without the re-arm guard would subtract the value twice. It also holds a wait whose threshold is not yet met and then tops the semaphore up from the bus, to show that blocking and release depend only on the compare.

// File: rtl/sem_evt_pkg.sv
package sem_evt_pkg;
  typedef enum logic [2:0] {
    WIN_EVT,
    WIN_RD,
    WIN_SET,
    WIN_INC,
    WIN_DEC,
    WIN_NONE
  } win_e;
endpackage

// File: rtl/sem_addr_dec.sv
module sem_addr_dec
  import sem_evt_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign idx_o   = addr_i[2 +: IDX_W];

  always_comb begin
    win_o = WIN_NONE;
    if (aligned) begin
      unique case (addr_i[ADDR_W-1 -: 3])
        3'b000:  win_o = WIN_EVT;
        3'b100:  win_o = WIN_RD;
        3'b101:  win_o = WIN_SET;
        3'b110:  win_o = WIN_INC;
        3'b111:  win_o = WIN_DEC;
        default: win_o = WIN_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sem_calc.sv
// base + add - sub_a - sub_b, clamped to [0, 2^W-1]
module sem_calc #(
  parameter int W = 32
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] add_i,
  input  logic [W-1:0] sub_a_i,
  input  logic [W-1:0] sub_b_i,
  output logic [W-1:0] res_o,
  output logic         uflow_o
);
  logic [W+2:0] sum;
  assign sum = {3'b000, base_i} + {3'b000, add_i} - {3'b000, sub_a_i} - {3'b000, sub_b_i};

  always_comb begin
    uflow_o = 1'b0;
    if (sum[W+2]) begin
      res_o   = '0;
      uflow_o = 1'b1;
    end else if (sum[W+1:W] != 2'b00) begin
      res_o = '1;
    end else begin
      res_o = sum[W-1:0];
    end
  end
endmodule

// File: rtl/evt_strobe.sv
module evt_strobe #(
  parameter int NUM_EVT = 256,
  parameter int IDX_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [NUM_EVT-1:0] evt_o
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_o[g] <= 1'b0;
      else         evt_o[g] <= fire_i && (idx_i == IDX_W'(g));
    end
  end
endmodule

// File: rtl/sem_evt_unit.sv
module sem_evt_unit
  import sem_evt_pkg::*;
#(
  parameter int NUM_SEM = 256,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 13,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [CNT_W-1:0]   bus_wdata_i,
  output logic [CNT_W-1:0]   bus_rdata_o,
  output logic               bus_rvalid_o,
  output logic [NUM_SEM-1:0] evt_o,
  input  logic               eng_req_i,
  input  logic [IDX_W-1:0]   eng_sem_i,
  input  logic [CNT_W-1:0]   eng_val_i,
  input  logic               eng_dec_i,
  input  logic               eng_notify_i,
  output logic               eng_done_o,
  output logic               ntf_valid_o,
  output logic [IDX_W-1:0]   ntf_sem_o,
  output logic               ntf_mode_o,
  output logic [CNT_W-1:0]   ntf_value_o
);
  logic [CNT_W-1:0]   cnt_q [NUM_SEM];
  logic [NUM_SEM-1:0] uflow_q;
  logic               done_q, ntf_valid_q, ntf_mode_q;
  logic [IDX_W-1:0]   ntf_sem_q;

  win_e             win;
  logic [IDX_W-1:0] bidx;

  sem_addr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr_i(bus_addr_i), .win_o(win), .idx_o(bidx)
  );

  logic bus_wr, sem_wr;
  assign bus_wr = bus_req_i && bus_we_i;
  assign sem_wr = bus_wr && (win == WIN_SET || win == WIN_INC || win == WIN_DEC);

  // engine lane: compare against pre-cycle count, suppressed while done is shown
  logic [CNT_W-1:0] eng_cur, eng_sub;
  logic             eng_fire, eng_upd, same;
  assign eng_cur  = cnt_q[eng_sem_i];
  assign eng_fire = eng_req_i && !done_q && (eng_cur >= eng_val_i);
  assign eng_upd  = eng_fire && eng_dec_i;
  assign eng_sub  = eng_upd ? eng_val_i : '0;
  assign same     = sem_wr && (bidx == eng_sem_i);

  // bus lane, absorbs the engine decrement when indices collide
  logic [CNT_W-1:0] a_base, a_add, a_sub, a_res, b_res;
  logic             a_uf, b_uf;
  assign a_base = (win == WIN_SET) ? bus_wdata_i : cnt_q[bidx];
  assign a_add  = (win == WIN_INC) ? bus_wdata_i : '0;
  assign a_sub  = (win == WIN_DEC) ? bus_wdata_i : '0;

  sem_calc #(.W(CNT_W)) u_calc_bus (
    .base_i(a_base), .add_i(a_add), .sub_a_i(a_sub),
    .sub_b_i(same ? eng_sub : '0), .res_o(a_res), .uflow_o(a_uf)
  );

  sem_calc #(.W(CNT_W)) u_calc_eng (
    .base_i(eng_cur), .add_i('0), .sub_a_i(eng_sub),
    .sub_b_i('0), .res_o(b_res), .uflow_o(b_uf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SEM; i++) cnt_q[i] <= '0;
      uflow_q <= '0;
    end else begin
      if (sem_wr) begin
        cnt_q[bidx]   <= a_res;
        uflow_q[bidx] <= (win == WIN_SET) ? a_uf : (uflow_q[bidx] | a_uf);
      end
      if (eng_upd && !same) begin
        cnt_q[eng_sem_i]   <= b_res;
        uflow_q[eng_sem_i] <= uflow_q[eng_sem_i] | b_uf;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      ntf_valid_q <= 1'b0;
      ntf_mode_q  <= 1'b0;
      ntf_sem_q   <= '0;
    end else begin
      done_q      <= eng_fire;
      ntf_valid_q <= eng_fire && eng_notify_i;
      if (eng_fire) begin
        ntf_mode_q <= eng_dec_i;
        ntf_sem_q  <= eng_sem_i;
      end
    end
  end

  assign eng_done_o  = done_q;
  assign ntf_valid_o = ntf_valid_q;
  assign ntf_mode_o  = ntf_mode_q;
  assign ntf_sem_o   = ntf_sem_q;
  assign ntf_value_o = cnt_q[ntf_sem_q];

  // read path
  logic [CNT_W-1:0] rdata_q;
  logic             rvalid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_req_i && !bus_we_i;
      if (bus_req_i && !bus_we_i) begin
        unique case (win)
          WIN_RD:  rdata_q <= cnt_q[bidx];
          WIN_SET: rdata_q <= {{(CNT_W-1){1'b0}}, uflow_q[bidx]};
          default: rdata_q <= '0;
        endcase
      end
    end
  end
  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  evt_strobe #(.NUM_EVT(NUM_SEM), .IDX_W(IDX_W)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(bus_wr && win == WIN_EVT),
    .idx_i(bidx), .evt_o(evt_o)
  );

  assert_evt_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_o));
  assert_done_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_o |-> $past(eng_req_i));
  assert_single_fire_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_o |=> !eng_done_o);
  assert_ntf_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> eng_done_o);
  assert_rvalid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> $past(bus_req_i && !bus_we_i));
  assert_uflow_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(uflow_q) < $countones($past(uflow_q))) |->
      $past(bus_req_i && bus_we_i && bus_addr_i[ADDR_W-1 -: 3] == 3'b101));
endmodule

// File: tb/sem_evt_unit_test.sv
module sem_evt_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_req = 0, bus_we = 0;
  logic [12:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [255:0] evt;
  logic         eng_req = 0, eng_dec = 0, eng_notify = 0;
  logic [7:0]   eng_sem = '0;
  logic [31:0]  eng_val = '0;
  logic         eng_done, ntf_valid, ntf_mode;
  logic [7:0]   ntf_sem;
  logic [31:0]  ntf_value;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sem_evt_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .evt_o(evt),
    .eng_req_i(eng_req), .eng_sem_i(eng_sem), .eng_val_i(eng_val),
    .eng_dec_i(eng_dec), .eng_notify_i(eng_notify), .eng_done_o(eng_done),
    .ntf_valid_o(ntf_valid), .ntf_sem_o(ntf_sem), .ntf_mode_o(ntf_mode),
    .ntf_value_o(ntf_value)
  );

  localparam logic [12:0] W_EVT = 13'h0000, W_RD = 13'h1000, W_SET = 13'h1400,
                          W_INC = 13'h1800, W_DEC = 13'h1C00;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic bwr(input logic [12:0] win, input int k, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = win + 13'(4 * k); bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic brd(input logic [12:0] win, input int k, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = win + 13'(4 * k);
    @(negedge clk);
    bus_req = 0;
    chk(bus_rvalid === 1'b1, "R2 rvalid", 256'(bus_rvalid), 256'd1);
    d = bus_rdata;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    chk(evt === '0, "R1 evt", evt, 0);
    chk(eng_done === 0 && ntf_valid === 0, "R1 done", 256'({eng_done, ntf_valid}), 0);
    brd(W_RD, 0, d);   chk(d === 0, "R1 sem0", 256'(d), 0);
    brd(W_RD, 255, d); chk(d === 0, "R1 sem255", 256'(d), 0);
    brd(W_SET, 5, d);  chk(d === 0, "R1 uflow", 256'(d), 0);
  endtask

  task automatic test_set_read();
    logic [31:0] d;
    bwr(W_SET, 0, 32'h1234_5678);
    bwr(W_SET, 255, 32'hCAFE_0001);
    brd(W_RD, 0, d);   chk(d === 32'h1234_5678, "R2 sem0", 256'(d), 256'h12345678);
    brd(W_RD, 255, d); chk(d === 32'hCAFE_0001, "R6 sem255", 256'(d), 256'hCAFE0001);
  endtask

  task automatic test_unmapped();
    logic [31:0] d;
    bwr(13'h0400, 0, 32'h0);         // window 001
    bwr(W_SET + 13'd1, 0, 32'h0);    // misaligned
    brd(W_RD, 0, d); chk(d === 32'h1234_5678, "R6 ignored", 256'(d), 256'h12345678);
  endtask

  task automatic test_inc();
    logic [31:0] d;
    bwr(W_SET, 1, 32'd7);
    bwr(W_INC, 1, 32'd1);
    brd(W_RD, 1, d); chk(d === 32'd8, "R3 inc", 256'(d), 8);
    bwr(W_SET, 1, 32'hFFFF_FFF0);
    bwr(W_INC, 1, 32'h20);
    brd(W_RD, 1, d); chk(d === 32'hFFFF_FFFF, "R3 sat", 256'(d), 256'hFFFFFFFF);
  endtask

  task automatic test_dec();
    logic [31:0] d;
    bwr(W_SET, 2, 32'd10);
    bwr(W_DEC, 2, 32'd4);
    brd(W_RD, 2, d);  chk(d === 32'd6, "R4 dec", 256'(d), 6);
    brd(W_SET, 2, d); chk(d === 0, "R4 no uflow", 256'(d), 0);
    bwr(W_DEC, 2, 32'd9);
    brd(W_RD, 2, d);  chk(d === 0, "R4 clamp", 256'(d), 0);
    brd(W_SET, 2, d); chk(d === 1, "R4 uflow set", 256'(d), 1);
    bwr(W_INC, 2, 32'd3);
    brd(W_SET, 2, d); chk(d === 1, "R4 sticky", 256'(d), 1);
    bwr(W_SET, 2, 32'd3);
    brd(W_SET, 2, d); chk(d === 0, "R4 cleared", 256'(d), 0);
  endtask

  task automatic test_event();
    logic [31:0] d;
    logic [255:0] e;
    bwr(W_EVT, 77, 32'h1);
    e = '0; e[77] = 1'b1;
    chk(evt === e, "R5 strobe", evt, e);
    @(negedge clk);
    chk(evt === '0, "R5 one cycle", evt, 0);
    brd(W_EVT, 77, d); chk(d === 0, "R5 read zero", 256'(d), 0);
  endtask

  task automatic test_wait_plain();
    logic [31:0] d;
    bwr(W_SET, 20, 32'd6);
    eng_sem = 20; eng_val = 7; eng_dec = 0; eng_notify = 1; eng_req = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(eng_done === 0, "R7 blocks", 256'(eng_done), 0);
    end
    eng_req = 0; eng_val = 6;
    @(negedge clk);
    eng_req = 1;
    @(negedge clk);
    eng_req = 0;
    chk(eng_done === 1, "R7 done", 256'(eng_done), 1);
    chk(ntf_valid === 1 && ntf_mode === 0 && ntf_sem === 8'd20 && ntf_value === 32'd6,
        "R9 plain ntf", 256'({ntf_valid, ntf_mode, ntf_sem, ntf_value}),
        256'({1'b1, 1'b0, 8'd20, 32'd6}));
    brd(W_RD, 20, d); chk(d === 32'd6, "R7 unchanged", 256'(d), 6);
  endtask

  task automatic test_wait_dec();
    logic [31:0] d;
    bwr(W_SET, 3, 32'd2);
    eng_sem = 3; eng_val = 5; eng_dec = 1; eng_notify = 1; eng_req = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(eng_done === 0, "R8 blocks", 256'(eng_done), 0);
    end
    bwr(W_INC, 3, 32'd3);
    chk(eng_done === 0, "R8 still blocked", 256'(eng_done), 0);
    @(negedge clk);
    eng_req = 0;
    chk(eng_done === 1, "R8 done", 256'(eng_done), 1);
    chk(ntf_valid === 1 && ntf_mode === 1 && ntf_sem === 8'd3 && ntf_value === 32'd0,
        "R9 dec ntf", 256'({ntf_valid, ntf_mode, ntf_sem, ntf_value}),
        256'({1'b1, 1'b1, 8'd3, 32'd0}));
    brd(W_RD, 3, d);  chk(d === 0, "R8 decremented", 256'(d), 0);
    brd(W_SET, 3, d); chk(d === 0, "R8 no uflow", 256'(d), 0);
  endtask

  task automatic test_no_notify();
    bwr(W_SET, 4, 32'd1);
    eng_sem = 4; eng_val = 1; eng_dec = 1; eng_notify = 0; eng_req = 1;
    @(negedge clk);
    eng_req = 0;
    chk(eng_done === 1 && ntf_valid === 0, "R9 no ntf",
        256'({eng_done, ntf_valid}), 256'(2'b10));
  endtask

  task automatic test_merge();
    logic [31:0] d;
    bwr(W_SET, 7, 32'd10);
    eng_sem = 7; eng_val = 4; eng_dec = 1; eng_notify = 0; eng_req = 1;
    bwr(W_INC, 7, 32'd3);
    eng_req = 0;
    chk(eng_done === 1, "R10 done", 256'(eng_done), 1);
    brd(W_RD, 7, d); chk(d === 32'd9, "R10 inc+dec", 256'(d), 9);
    eng_req = 1;
    bwr(W_DEC, 7, 32'd8);
    eng_req = 0;
    brd(W_RD, 7, d);  chk(d === 0, "R10 clamp", 256'(d), 0);
    brd(W_SET, 7, d); chk(d === 1, "R10 uflow", 256'(d), 1);
  endtask

  task automatic test_hold();
    logic [31:0] d;
    bwr(W_SET, 9, 32'd10);
    eng_sem = 9; eng_val = 3; eng_dec = 1; eng_notify = 0; eng_req = 1;
    @(negedge clk);
    chk(eng_done === 1, "R11 first", 256'(eng_done), 1);
    @(negedge clk);
    eng_req = 0;
    chk(eng_done === 0, "R11 no refire", 256'(eng_done), 0);
    brd(W_RD, 9, d); chk(d === 32'd7, "R11 once", 256'(d), 7);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_set_read();
    test_unmapped();
    test_inc();
    test_dec();
    test_event();
    test_wait_plain();
    test_wait_dec();
    test_no_notify();
    test_merge();
    test_hold();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule